// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Core

This block is the request, in-service and acknowledge datapath of an eight-line interrupt controller. It records single-cycle request pulses that are not masked, tracks which lines the processor is servicing, and drives one interrupt output to the processor. Line 7 has the highest priority and line 0 the lowest. A request raises the output only when no in-service bit is set at or above its own line.

When the processor pulses the acknowledge strobe, the block picks the highest pending request, clears it and marks that line as in service. In auto-end mode the line is ended straight away instead. In the next cycle the block returns the vector, which is the vector base with the line number in its low three bits. If the line is mapped to an attached secondary controller, it instead flags that the secondary must supply the vector and names the cascaded line. End-of-interrupt commands clear one in-service bit and can raise the output again for a waiting request.

Top module: `irq_ack_core`

## Requirements
- R1: A request pulse on a line whose mask bit is 1 leaves that line's pending bit unchanged. A pulse on an unmasked line sets its pending bit.
- R2: One cycle after an unmasked pulse on line L, int_out is 1 if all in-service bits from L up to 7 are clear. If any of them is set, the pulse does not raise int_out.
- R3: An acknowledge with requests pending selects the highest-numbered pending line and clears its pending bit.
- R4: When auto_eoi is 1 during an acknowledge, the selected line is left out of service: its in-service bit is cleared, not set. When auto_eoi is 0, its in-service bit is set.
- R5: One cycle after an acknowledge of line L with no cascade, vec_valid is 1 for one cycle and vec equals {vec_base_hi, L[2:0]}.
- R6: If cascade_map[L] and sec_present are both 1 for the acknowledged line L, the next cycle shows cas_valid = 1, vec_valid = 0 and cas_line = L. In-service handling is the same as in R4.
- R7: An EOI on line N clears in-service bit N. If requests remain pending afterwards and the highest of them passes the in-service check of R2, int_out becomes 1.
- R8: After an acknowledge, int_out is 1 only if the highest remaining pending line passes the in-service check. Otherwise it drops to 0.
- R9: An acknowledge while nothing is pending returns vec = {vec_base_hi, 3'b111} with vec_valid = 1, and changes no pending or in-service bit.
- R10: Inputs that arrive in the same cycle are applied in this order: acknowledge, then EOI, then new request pulses. A pulse that arrives with an EOI is therefore checked against the in-service bits after the EOI.
- R11: After reset, no line is pending or in service, and int_out, vec_valid and cas_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pulse | input | 8 | Single-cycle request pulse per line |
| irq_mask | input | 8 | 1 blocks requests on that line |
| cascade_map | input | 8 | 1 marks a line that a secondary controller feeds |
| sec_present | input | 1 | A secondary controller is attached |
| auto_eoi | input | 1 | End each interrupt at acknowledge time |
| vec_base_hi | input | 5 | Upper bits of the vector |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_line | input | 3 | Line whose in-service bit the EOI clears |
| ack | input | 1 | Single-cycle acknowledge strobe |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | vec is valid this cycle |
| vec | output | 8 | Returned vector |
| cas_valid | output | 1 | The secondary controller must supply the vector |
| cas_line | output | 3 | Cascaded line being acknowledged |

## Verification
Pending and in-service bits cannot be read at the ports, so any fault in them shows up in int_out or in the next vector. A lost or extra pending bit changes the vector of the next acknowledge, one cycle after that strobe. A stuck in-service bit keeps int_out low after a lower-line pulse, or after an EOI, within one cycle. An error in the same-cycle ordering shows up when an EOI and a pulse arrive together.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
   typedef enum logic [1:0] {
      RES_NONE = 2'd0,
      RES_VEC  = 2'd1,
      RES_CAS  = 2'd2
   } ack_res_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int W  = 8,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/irq_svc_gate.sv
module irq_svc_gate #(
   parameter int W  = 8,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  isr,
   input  logic [IW-1:0] line,
   output logic          pass
);
   logic [W-1:0] clear_from;
   for (genvar g = 0; g < W; g++) begin : g_line
      assign clear_from[g] = ~|isr[W-1:g];
   end
   assign pass = clear_from[line];
endmodule

// File: rtl/irq_ack_core.sv
module irq_ack_core
   import irq_core_pkg::*;
#(
   parameter int LINES = 8,
   parameter int VEC_W = 8,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LINES-1:0]       irq_pulse,
   input  logic [LINES-1:0]       irq_mask,
   input  logic [LINES-1:0]       cascade_map,
   input  logic                   sec_present,
   input  logic                   auto_eoi,
   input  logic [VEC_W-IDX_W-1:0] vec_base_hi,
   input  logic                   eoi_valid,
   input  logic [IDX_W-1:0]       eoi_line,
   input  logic                   ack,
   output logic                   int_out,
   output logic                   vec_valid,
   output logic [VEC_W-1:0]       vec,
   output logic                   cas_valid,
   output logic [IDX_W-1:0]       cas_line
);
   if (LINES < 2 || (1 << IDX_W) != LINES || VEC_W <= IDX_W) begin : g_bad_cfg
      $error("irq_ack_core: LINES must be a power of two and VEC_W wider than the line index");
   end

   logic [LINES-1:0] irr, isr, irr_a, isr_a, isr_e, irr_d, acc;
   logic             int_q, int_d;
   ack_res_e         res_q, res_d;
   logic [VEC_W-1:0] vec_q, vec_d;
   logic [IDX_W-1:0] line_q, line_d;
   logic             a_any, r_any, n_any;
   logic [IDX_W-1:0] a_idx, r_idx, n_idx;
   logic             p_ack, p_eoi, p_new;

   assign acc = irq_pulse & ~irq_mask;

   irq_prio_enc #(.W(LINES), .IW(IDX_W)) u_enc_ack (.req(irr),   .any(a_any), .idx(a_idx));
   irq_prio_enc #(.W(LINES), .IW(IDX_W)) u_enc_rem (.req(irr_a), .any(r_any), .idx(r_idx));
   irq_prio_enc #(.W(LINES), .IW(IDX_W)) u_enc_new (.req(acc),   .any(n_any), .idx(n_idx));

   irq_svc_gate #(.W(LINES), .IW(IDX_W)) u_gate_ack (.isr(isr_a), .line(r_idx), .pass(p_ack));
   irq_svc_gate #(.W(LINES), .IW(IDX_W)) u_gate_eoi (.isr(isr_e), .line(r_idx), .pass(p_eoi));
   irq_svc_gate #(.W(LINES), .IW(IDX_W)) u_gate_new (.isr(isr_e), .line(n_idx), .pass(p_new));

   // stage 1: acknowledge on the current registers
   always_comb begin
      irr_a  = irr;
      isr_a  = isr;
      res_d  = RES_NONE;
      vec_d  = vec_q;
      line_d = line_q;
      if (ack) begin
         if (a_any) begin
            irr_a[a_idx] = 1'b0;
            isr_a[a_idx] = ~auto_eoi;
            vec_d        = {vec_base_hi, a_idx};
            line_d       = a_idx;
            res_d        = (cascade_map[a_idx] && sec_present) ? RES_CAS : RES_VEC;
         end else begin
            vec_d = {vec_base_hi, {IDX_W{1'b1}}};
            res_d = RES_VEC;
         end
      end
   end

   // stage 2: end of interrupt, stage 3: new requests
   always_comb begin
      isr_e = isr_a;
      if (eoi_valid) isr_e[eoi_line] = 1'b0;
      int_d = ack ? (r_any && p_ack) : int_q;
      if (eoi_valid && r_any && p_eoi) int_d = 1'b1;
      if (n_any && p_new) int_d = 1'b1;
      irr_d = irr_a | acc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr    <= '0;
         isr    <= '0;
         int_q  <= 1'b0;
         res_q  <= RES_NONE;
         vec_q  <= '0;
         line_q <= '0;
      end else begin
         irr    <= irr_d;
         isr    <= isr_e;
         int_q  <= int_d;
         res_q  <= res_d;
         vec_q  <= vec_d;
         line_q <= line_d;
      end
   end

   assign int_out   = int_q;
   assign vec_valid = (res_q == RES_VEC);
   assign cas_valid = (res_q == RES_CAS);
   assign vec       = vec_q;
   assign cas_line  = line_q;

   AST_NO_MASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((irr & ~$past(irr) & ($past(irq_mask) | ~$past(irq_pulse))) == '0)); // R1
   AST_ACK_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (|irr)) |=> (vec_valid || cas_valid)); // R3
   AST_AUTO_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && auto_eoi) |=> ($countones(isr) <= $countones($past(isr)))); // R4
   AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid |=> !isr[$past(eoi_line)]); // R7
   AST_LAST_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !eoi_valid && (acc == '0) && ($countones(irr) == 1)) |=> !int_out); // R8
   AST_EMPTY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (irr == '0)) |=> (vec_valid && (vec[IDX_W-1:0] == {IDX_W{1'b1}}))); // R9
endmodule

// File: tb/tb_irq_ack_core.sv
module tb_irq_ack_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_pulse = '0, irq_mask = '0, cascade_map = '0;
   logic       sec_present = 1'b0, auto_eoi = 1'b0, eoi_valid = 1'b0, ack = 1'b0;
   logic [4:0] vec_base_hi = 5'b00100;
   logic [2:0] eoi_line = '0;
   logic       int_out, vec_valid, cas_valid;
   logic [7:0] vec;
   logic [2:0] cas_line;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [7:0] m_irr = '0, m_isr = '0, m_vec = '0;
   logic       m_int = 1'b0;
   int         m_res = 0;
   logic [2:0] m_line = '0;

   always #10 clk = ~clk;

   irq_ack_core dut (
      .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .irq_mask(irq_mask),
      .cascade_map(cascade_map), .sec_present(sec_present), .auto_eoi(auto_eoi),
      .vec_base_hi(vec_base_hi), .eoi_valid(eoi_valid), .eoi_line(eoi_line),
      .ack(ack), .int_out(int_out), .vec_valid(vec_valid), .vec(vec),
      .cas_valid(cas_valid), .cas_line(cas_line));

   function automatic int topl(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) if (v[i]) return i;
      return -1;
   endfunction

   function automatic bit passes(input logic [7:0] s, input int l);
      return (s >> l) == 8'd0;
   endfunction

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
      end
   endtask

   // model of one clock edge: acknowledge, then EOI, then new pulses (R10)
   task automatic model_edge();
      logic [7:0] irr_a, isr_a, isr_e, accm;
      int t, r, n;
      bit f;
      irr_a = m_irr; isr_a = m_isr; m_res = 0;
      if (ack) begin
         t = topl(m_irr);
         if (t >= 0) begin
            irr_a[t] = 1'b0;
            isr_a[t] = ~auto_eoi;
            m_vec = {vec_base_hi, 3'(t)};
            m_line = 3'(t);
            m_res = (cascade_map[t] && sec_present) ? 2 : 1;
         end else begin
            m_vec = {vec_base_hi, 3'b111};
            m_res = 1;
         end
      end
      isr_e = isr_a;
      if (eoi_valid) isr_e[eoi_line] = 1'b0;
      r = topl(irr_a);
      f = ack ? (r >= 0 && passes(isr_a, r)) : m_int;
      if (eoi_valid && r >= 0 && passes(isr_e, r)) f = 1'b1;
      accm = irq_pulse & ~irq_mask;
      n = topl(accm);
      if (n >= 0 && passes(isr_e, n)) f = 1'b1;
      m_irr = irr_a | accm;
      m_isr = isr_e;
      m_int = f;
   endtask

   task automatic cyc(input logic [7:0] p, input bit a, input bit ev, input logic [2:0] el);
      irq_pulse = p; ack = a; eoi_valid = ev; eoi_line = el;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check("R2 int_out", int_out, m_int);
      check("R5 vec_valid", vec_valid, m_res == 1);
      if (m_res == 1) check("R5 vec", vec, m_vec);
      check("R6 cas_valid", cas_valid, m_res == 2);
      if (m_res == 2) check("R6 cas_line", cas_line, m_line);
      irq_pulse = '0; ack = 1'b0; eoi_valid = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5519));
      repeat (3) @(negedge clk);
      check("R11 int_out", int_out, 0);
      check("R11 vec_valid", vec_valid, 0);
      check("R11 cas_valid", cas_valid, 0);
      rst_n = 1'b1;

      // R1 and R9: masked pulse, then empty acknowledge
      irq_mask = 8'h10;
      cyc(8'h10, 0, 0, 0); check("R1 masked", int_out, 0);
      cyc(8'h00, 1, 0, 0); check("R9 empty vec", vec, 8'h27); check("R9 valid", vec_valid, 1);
      irq_mask = 8'h00;

      // R2, R3, R8, R7
      cyc(8'h44, 0, 0, 0); check("R2 raise", int_out, 1);
      cyc(8'h00, 1, 0, 0); check("R3 highest", vec, 8'h26); check("R8 drop", int_out, 0);
      cyc(8'h00, 0, 1, 3'd6); check("R7 reraise", int_out, 1);
      cyc(8'h00, 1, 0, 0); check("R3 next", vec, 8'h22); check("R8 empty", int_out, 0);
      cyc(8'h00, 0, 1, 3'd2);

      // R4 auto end
      auto_eoi = 1'b1;
      cyc(8'h08, 0, 0, 0);
      cyc(8'h00, 1, 0, 0); check("R4 vec", vec, 8'h23);
      cyc(8'h02, 0, 0, 0); check("R4 not in service", int_out, 1);
      cyc(8'h00, 1, 0, 0); check("R4 vec2", vec, 8'h21);
      auto_eoi = 1'b0;

      // R6 cascade
      cascade_map = 8'h04; sec_present = 1'b1;
      cyc(8'h04, 0, 0, 0);
      cyc(8'h00, 1, 0, 0);
      check("R6 cas", cas_valid, 1); check("R6 no vec", vec_valid, 0); check("R6 line", cas_line, 2);
      cyc(8'h00, 0, 1, 3'd2);
      sec_present = 1'b0;
      cyc(8'h04, 0, 0, 0);
      cyc(8'h00, 1, 0, 0); check("R6 no secondary", vec_valid, 1); check("R5 vec", vec, 8'h22);
      cyc(8'h00, 0, 1, 3'd2);
      cascade_map = 8'h00;

      // R2 blocking and R10 ordering
      cyc(8'h20, 0, 0, 0);
      cyc(8'h00, 1, 0, 0);
      cyc(8'h10, 0, 0, 0); check("R2 blocked", int_out, 0);
      cyc(8'h00, 1, 0, 0); check("R3 blocked line", vec, 8'h24);
      cyc(8'h00, 0, 1, 3'd4); check("R7 none pending", int_out, 0);
      cyc(8'h10, 0, 1, 3'd5); check("R10 eoi first", int_out, 1);
      cyc(8'h00, 1, 0, 0); check("R10 vec", vec, 8'h24);
      cyc(8'h00, 0, 1, 3'd4);

      // constrained random
      for (int k = 0; k < 4000; k++) begin
         logic [7:0] p;
         bit a, ev;
         logic [2:0] el;
         int ti;
         if ($urandom % 50 == 0) irq_mask = 8'($urandom) & 8'($urandom);
         if ($urandom % 80 == 0) auto_eoi = ~auto_eoi;
         if ($urandom % 60 == 0) cascade_map = 8'($urandom);
         if ($urandom % 60 == 0) sec_present = ~sec_present;
         if ($urandom % 200 == 0) vec_base_hi = 5'($urandom);
         p  = ($urandom % 3 == 0) ? (8'd1 << ($urandom % 8)) : 8'd0;
         if ($urandom % 20 == 0) p = p | 8'($urandom);
         a  = ($urandom % 5 == 0);
         ev = ($urandom % 5 == 0);
         ti = topl(m_isr);
         el = (ti >= 0 && ($urandom % 4 != 0)) ? 3'(ti) : 3'($urandom);
         cyc(p, a, ev, el);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule